// File: doc/BRIEF.md
# Memory Lock Bit Protection Controller

This block keeps a byte of one-way lock bits that guard an on-chip program and data memory, and turns them into grant or deny decisions for a programming port. The port can ask to write memory, read back (verify) memory, write the configuration fuses, write the boot-section lock field, or self-program from software. Each grant follows from the current lock byte and the request in the same cycle. A request that is refused raises an error pulse in the cycle after it.

The low two bits choose a protection level. A lock write can only move bits from 1 (unprogrammed) to 0 (programmed), because the written byte is ANDed into the stored byte. Only a chip erase brings the bits back to 1. The two unused top bits always read as 1. Self-programming does not depend on the lock bits. An active-low enable fuse input alone gates it.

Top module: `lockbit_guard`

## Requirements
- R1: After reset `lock_byte` is 8'hFF, no grant is high and `deny_err` is 0.
- R2: A lock write without erase makes the next `lock_byte` equal to the old byte AND `lock_wdata`. The exception is the boot field in R7. A 1 in the data never sets a programmed bit again, and bits 7..6 always read 1.
- R3: A chip erase makes `lock_byte` 8'hFF at the next edge. This holds even when a lock write is issued in the same cycle.
- R4: When `lock_byte[1:0]`=2'b11 (open level), memory write, memory read, fuse write and boot-field write requests are all granted.
- R5: When `lock_byte[1:0]`=2'b10 (no-write level), memory read and boot-field write are granted, and memory write and fuse write are denied.
- R6: When `lock_byte[1:0]` is 2'b00 or 2'b01 (sealed level), memory write, memory read, fuse write and boot-field write are all denied.
- R7: At the sealed level a lock write leaves the boot field `lock_byte[5:2]` unchanged. It still ANDs into bits 1..0.
- R8: `gnt_self_prog` is high exactly when `req_self_prog` is high and `self_prog_fuse_n` is 0, whatever the lock byte holds.
- R9: `deny_err` is high for one cycle after each cycle in which any request was refused, and low after a cycle with no refused request.
- R10: A grant is never high while its request is low, and it reacts in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_wr | input | 1 | Lock write command |
| lock_wdata | input | 8 | Data ANDed into the lock byte |
| chip_erase | input | 1 | Chip erase command, sets all lock bits to 1 |
| req_mem_wr | input | 1 | Memory write request |
| req_mem_rd | input | 1 | Memory read/verify request |
| req_fuse_wr | input | 1 | Fuse write request |
| req_boot_wr | input | 1 | Boot-field lock write request |
| req_self_prog | input | 1 | Software self-program request |
| self_prog_fuse_n | input | 1 | Self-program enable fuse, 0 = enabled |
| gnt_mem_wr | output | 1 | Memory write granted |
| gnt_mem_rd | output | 1 | Memory read granted |
| gnt_fuse_wr | output | 1 | Fuse write granted |
| gnt_boot_wr | output | 1 | Boot-field write granted |
| gnt_self_prog | output | 1 | Self-program granted |
| deny_err | output | 1 | One-cycle pulse after a refused request |
| lock_byte | output | 8 | Current lock byte |

## Verification
The assertions take it as given that inputs are stable around the clock edge and that reset is applied before the first command. Erase, lock writes and requests may arrive together in any combination. The stimulus changes inputs only on the falling edge. It takes the lock byte through every level, including the fail-safe 2'b01 code. It also issues erase and lock write in the same cycle, so the priority case is exercised without breaking those input assumptions.

// File: rtl/lockbit_pkg.sv
package lockbit_pkg;
   typedef enum logic [1:0] {
      LVL_OPEN    = 2'd0,
      LVL_NOWRITE = 2'd1,
      LVL_SEALED  = 2'd2
   } lock_level_e;

   typedef struct packed {
      logic mem_wr;
      logic mem_rd;
      logic fuse_wr;
      logic boot_wr;
   } perm_t;
endpackage

// File: rtl/lockbit_store.sv
module lockbit_store #(
   parameter int DATA_W = 8,
   parameter int BOOT_W = 4,
   parameter int MEM_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              erase,
   input  logic              boot_wr_ok,
   output logic [DATA_W-1:0] lock_q
);
   localparam int USED_W = BOOT_W + MEM_W;

   if (USED_W > DATA_W) begin : g_bad_width
      $error("lockbit_store: lock fields wider than the byte");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i >= USED_W) begin : g_pad
         assign lock_q[i] = 1'b1;
      end else begin : g_cell
         logic cell_q;
         logic cell_en;
         if (i >= MEM_W) begin : g_boot
            assign cell_en = wr_en & boot_wr_ok;
         end else begin : g_mem
            assign cell_en = wr_en;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cell_q <= 1'b1;
            else if (erase)                 cell_q <= 1'b1;
            else if (cell_en && !wdata[i])  cell_q <= 1'b0;
         end
         assign lock_q[i] = cell_q;
      end
   end

   AST_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !erase |=> ((lock_q & ~$past(lock_q)) == '0)); // R2
   AST_ERASE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (&lock_q)); // R3
   AST_WRITE_AND: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !erase) |=> ((lock_q[MEM_W-1:0] & ~$past(wdata[MEM_W-1:0])) == '0)); // R2
endmodule

// File: rtl/lockbit_decode.sv
module lockbit_decode
   import lockbit_pkg::*;
#(
   parameter int MEM_W = 2
) (
   input  logic [MEM_W-1:0] mem_bits,
   output lock_level_e      level,
   output perm_t            perm
);
   if (MEM_W != 2) begin : g_bad_mem
      $error("lockbit_decode: exactly two level bits are supported");
   end

   always_comb begin
      unique case (mem_bits)
         2'b11:   level = LVL_OPEN;
         2'b10:   level = LVL_NOWRITE;
         default: level = LVL_SEALED;
      endcase
   end

   always_comb begin
      perm = '0;
      case (level)
         LVL_OPEN:    perm = '{mem_wr: 1'b1, mem_rd: 1'b1, fuse_wr: 1'b1, boot_wr: 1'b1};
         LVL_NOWRITE: perm = '{mem_wr: 1'b0, mem_rd: 1'b1, fuse_wr: 1'b0, boot_wr: 1'b1};
         default:     perm = '0;
      endcase
   end
endmodule

// File: rtl/lockbit_guard.sv
module lockbit_guard
   import lockbit_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int BOOT_W  = 4,
   parameter int MEM_W   = 2,
   parameter bit SELF_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_wr,
   input  logic [DATA_W-1:0] lock_wdata,
   input  logic              chip_erase,
   input  logic              req_mem_wr,
   input  logic              req_mem_rd,
   input  logic              req_fuse_wr,
   input  logic              req_boot_wr,
   input  logic              req_self_prog,
   input  logic              self_prog_fuse_n,
   output logic              gnt_mem_wr,
   output logic              gnt_mem_rd,
   output logic              gnt_fuse_wr,
   output logic              gnt_boot_wr,
   output logic              gnt_self_prog,
   output logic              deny_err,
   output logic [DATA_W-1:0] lock_byte
);
   localparam int BOOT_LO = MEM_W;
   localparam int BOOT_HI = MEM_W + BOOT_W - 1;

   lock_level_e level;
   perm_t       perm;
   logic        refused;
   logic        err_q;

   lockbit_store #(.DATA_W(DATA_W), .BOOT_W(BOOT_W), .MEM_W(MEM_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (lock_wr),
      .wdata      (lock_wdata),
      .erase      (chip_erase),
      .boot_wr_ok (perm.boot_wr),
      .lock_q     (lock_byte)
   );

   lockbit_decode #(.MEM_W(MEM_W)) u_decode (
      .mem_bits (lock_byte[MEM_W-1:0]),
      .level    (level),
      .perm     (perm)
   );

   assign gnt_mem_wr  = req_mem_wr  & perm.mem_wr;
   assign gnt_mem_rd  = req_mem_rd  & perm.mem_rd;
   assign gnt_fuse_wr = req_fuse_wr & perm.fuse_wr;
   assign gnt_boot_wr = req_boot_wr & perm.boot_wr;

   if (SELF_EN) begin : g_self
      assign gnt_self_prog = req_self_prog & ~self_prog_fuse_n;
   end else begin : g_noself
      assign gnt_self_prog = 1'b0;
   end

   assign refused = (req_mem_wr    & ~gnt_mem_wr)  | (req_mem_rd  & ~gnt_mem_rd)
                  | (req_fuse_wr   & ~gnt_fuse_wr) | (req_boot_wr & ~gnt_boot_wr)
                  | (req_self_prog & ~gnt_self_prog);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= refused;
   end
   assign deny_err = err_q;

   AST_SEALED_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_byte[1] == 1'b0) |-> !(gnt_mem_wr | gnt_mem_rd | gnt_fuse_wr | gnt_boot_wr)); // R6
   AST_NOWRITE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_byte[0] == 1'b0) |-> !(gnt_mem_wr | gnt_fuse_wr)); // R5
   AST_SEALED_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && !chip_erase && !lock_byte[1]) |=> $stable(lock_byte[BOOT_HI:BOOT_LO])); // R7
   AST_SELF_FUSE: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_self_prog |-> (req_self_prog && !self_prog_fuse_n)); // R8
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_mem_wr && !gnt_mem_wr) |=> deny_err); // R9
   AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !((gnt_mem_wr && !req_mem_wr) || (gnt_mem_rd && !req_mem_rd)
        || (gnt_fuse_wr && !req_fuse_wr) || (gnt_boot_wr && !req_boot_wr))); // R10
endmodule

// File: tb/lockbit_guard_bench.sv
module lockbit_guard_bench;
   typedef struct {
      logic [7:0] lock;
      logic [4:0] gnt;
      logic       err;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lock_wr = 1'b0, chip_erase = 1'b0;
   logic [7:0] lock_wdata = 8'hFF;
   logic       req_mem_wr = 0, req_mem_rd = 0, req_fuse_wr = 0, req_boot_wr = 0;
   logic       req_self_prog = 0, self_prog_fuse_n = 1;
   logic       gnt_mem_wr, gnt_mem_rd, gnt_fuse_wr, gnt_boot_wr, gnt_self_prog;
   logic       deny_err;
   logic [7:0] lock_byte;

   int checks = 0;
   int errors = 0;
   exp_t q[$];
   logic [7:0] m_lock = 8'hFF;
   logic       m_err = 1'b0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   lockbit_guard u_lockbit_guard (
      .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr), .lock_wdata(lock_wdata),
      .chip_erase(chip_erase), .req_mem_wr(req_mem_wr), .req_mem_rd(req_mem_rd),
      .req_fuse_wr(req_fuse_wr), .req_boot_wr(req_boot_wr),
      .req_self_prog(req_self_prog), .self_prog_fuse_n(self_prog_fuse_n),
      .gnt_mem_wr(gnt_mem_wr), .gnt_mem_rd(gnt_mem_rd), .gnt_fuse_wr(gnt_fuse_wr),
      .gnt_boot_wr(gnt_boot_wr), .gnt_self_prog(gnt_self_prog),
      .deny_err(deny_err), .lock_byte(lock_byte)
   );

   // reqs order: {mem_wr, mem_rd, fuse_wr, boot_wr}
   task automatic step(input logic lw, input logic [7:0] wd, input logic er,
                       input logic [3:0] reqs, input logic sp, input logic fuse,
                       input string tag);
      logic [3:0] perm;
      logic [4:0] g;
      logic [7:0] mask;
      @(negedge clk);
      lock_wr = lw; lock_wdata = wd; chip_erase = er;
      {req_mem_wr, req_mem_rd, req_fuse_wr, req_boot_wr} = reqs;
      req_self_prog = sp; self_prog_fuse_n = fuse;
      case (m_lock[1:0])
         2'b11:   perm = 4'b1111;
         2'b10:   perm = 4'b0101;
         default: perm = 4'b0000;
      endcase
      g = {reqs & perm, sp & ~fuse};
      q.push_back('{lock: m_lock, gnt: g, err: m_err, tag: tag});
      m_err = (|(reqs & ~perm)) | (sp & fuse);
      if (er) m_lock = 8'hFF;
      else if (lw) begin
         mask = wd | 8'hC0;
         if (m_lock[1] == 1'b0) mask[5:2] = 4'hF;
         m_lock = (m_lock & mask) | 8'hC0;
      end
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (lock_byte !== e.lock) begin
               errors++;
               $display("FAIL %s lock_byte actual=%h expected=%h", e.tag, lock_byte, e.lock);
            end
            checks++;
            if ({gnt_mem_wr, gnt_mem_rd, gnt_fuse_wr, gnt_boot_wr, gnt_self_prog} !== e.gnt) begin
               errors++;
               $display("FAIL %s grants actual=%b expected=%b", e.tag,
                  {gnt_mem_wr, gnt_mem_rd, gnt_fuse_wr, gnt_boot_wr, gnt_self_prog}, e.gnt);
            end
            checks++;
            if (deny_err !== e.err) begin
               errors++;
               $display("FAIL %s deny_err actual=%b expected=%b", e.tag, deny_err, e.err);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(0, 8'hFF, 0, 4'b0000, 0, 1, "R1");
      step(0, 8'hFF, 0, 4'b1111, 0, 1, "R4");
      step(0, 8'hFF, 0, 4'b1010, 0, 1, "R10");
      step(0, 8'hFF, 0, 4'b0000, 0, 1, "R9");
      step(1, 8'h3E, 0, 4'b0000, 0, 1, "R2");
      step(0, 8'hFF, 0, 4'b1111, 0, 1, "R5");
      step(0, 8'hFF, 0, 4'b0000, 0, 1, "R9");
      step(1, 8'hFF, 0, 4'b0000, 0, 1, "R2");
      step(0, 8'hFF, 0, 4'b0101, 0, 1, "R5");
      step(0, 8'hFF, 0, 4'b0000, 1, 0, "R8");
      step(0, 8'hFF, 0, 4'b0000, 1, 1, "R8");
      step(0, 8'hFF, 0, 4'b0000, 0, 0, "R9");
      step(1, 8'hFC, 0, 4'b0000, 0, 1, "R2");
      step(0, 8'hFF, 0, 4'b1111, 0, 1, "R6");
      step(1, 8'hC3, 0, 4'b0000, 0, 1, "R7");
      step(0, 8'hFF, 0, 4'b0100, 1, 0, "R7");
      step(1, 8'h00, 1, 4'b0000, 0, 1, "R3");
      step(0, 8'hFF, 0, 4'b1111, 0, 1, "R3");
      step(1, 8'hFD, 0, 4'b0000, 0, 1, "R2");
      step(0, 8'hFF, 0, 4'b1111, 0, 1, "R6");
      step(1, 8'h00, 0, 4'b0000, 0, 1, "R7");
      step(0, 8'hFF, 1, 4'b0000, 0, 1, "R3");
      step(0, 8'hFF, 0, 4'b1111, 1, 0, "R4");
      step(0, 8'hFF, 0, 4'b0000, 0, 1, "R1");
      @(negedge clk);
      lock_wr = 0; chip_erase = 0;
      {req_mem_wr, req_mem_rd, req_fuse_wr, req_boot_wr, req_self_prog} = '0;
      wait (q.size() == 0);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule